// File: doc/BRIEF.md
# Run-Time Filled Result Reuse Table

This block keeps recently executed computational instructions, each stored as an opcode, two operand values and a result, so that a later instance of the same operation with the same operand values can take its result from the table. Nothing is preloaded. Every instruction that reaches writeback is offered to the update port. A lookup port checks the opcode and both operands in the same cycle it is presented and returns a hit flag and the stored result.

The storage is organised as a small number of sets, each holding a fixed number of ways. A set is claimed by one opcode, and an opcode never owns more than one set. Inside a set, ways are replaced least-recently-used first. When an opcode arrives that owns no set and every set is taken, the least recently used set is emptied as a whole and handed to the new opcode. Two saturating counters report how many single entries and how many whole sets have been thrown out.

Top module: `memo_table`

## Requirements
- R1: When `lk_valid_i` is high and some way holds the presented opcode and both operand values, `lk_hit_o` is high in that same cycle and `lk_result_o` carries the stored result. When `lk_valid_i` is low, `lk_hit_o` is low.
- R2: An update is written at the clock edge where `up_valid_i` is high. A lookup of the same opcode and operands in the following cycle hits and returns the written result.
- R3: An update whose opcode already owns a set is always written into that set. It never causes a set eviction.
- R4: An update that opens a new entry in an owned set takes the lowest-index empty way. If the set is full, it replaces the least recently used way.
- R5: An update with an opcode that owns no set claims the lowest-index set that no opcode owns. If every set is owned, the least recently used set loses all of its entries and is re-tagged with the new opcode.
- R6: A lookup hit makes both the matched way and its set most recently used. When a lookup and an update happen in the same cycle, the lookup's recency change is applied first, and any victim choice made by the update sees it.
- R7: An update whose opcode and both operands match a stored entry overwrites that entry's result in place and makes it most recently used. It does not count as an eviction.
- R8: `ent_evict_cnt_o` rises by one for each update that replaces a valid way in a full owned set. It holds at its all-ones value once there.
- R9: `set_evict_cnt_o` rises by one for each set taken away from its opcode. It holds at its all-ones value once there.
- R10: After reset every lookup misses and both counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_opc_i | input | OPC_W | Lookup opcode |
| lk_a_i | input | DATA_W | Lookup first operand |
| lk_b_i | input | DATA_W | Lookup second operand |
| lk_hit_o | output | 1 | Lookup found a matching entry |
| lk_result_o | output | DATA_W | Stored result on a hit, zero otherwise |
| up_valid_i | input | 1 | Writeback update request |
| up_opc_i | input | OPC_W | Update opcode |
| up_a_i | input | DATA_W | Update first operand |
| up_b_i | input | DATA_W | Update second operand |
| up_result_i | input | DATA_W | Update result |
| ent_evict_cnt_o | output | CNT_W | Saturating count of single-entry replacements |
| set_evict_cnt_o | output | CNT_W | Saturating count of whole-set evictions |

## Verification
The bench targets the ordering corner cases. The first is a lookup hit to the set that was oldest, in the same cycle as a new opcode forces a set eviction. A design that picked the victim before applying the lookup's recency change would throw away the set just used, and the next lookup to it would miss. The second is a repeated update with identical operands. If that update inserted a duplicate instead of refreshing, the set would fill early and the entry counter would move. After a set eviction, the old opcode's entries must miss and the new entry must land in way 0; a design that kept stale valid bits would return old results under the new tag. Saturation of both counters is driven past the all-ones value, and a wrap to zero shows up at once.

// File: rtl/memo_pkg.sv
package memo_pkg;
  localparam int unsigned MEMO_OPC_W  = 6;
  localparam int unsigned MEMO_DATA_W = 16;
  localparam int unsigned MEMO_SETS   = 4;
  localparam int unsigned MEMO_WAYS   = 4;
  localparam int unsigned MEMO_CNT_W  = 16;

  typedef enum logic [2:0] {
    UPD_IDLE,
    UPD_REFRESH,
    UPD_FILL,
    UPD_REPLACE,
    UPD_CLAIM,
    UPD_EVICT
  } upd_kind_e;
endpackage

// File: rtl/memo_lru_age.sv
// Age-rank LRU: rank 0 is MRU, rank N-1 is LRU. Two touches per cycle, a then b.
module memo_lru_age #(
  parameter int unsigned N = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_en_i,
  input  logic [IW-1:0] a_idx_i,
  input  logic          b_en_i,
  input  logic [IW-1:0] b_idx_i,
  output logic [IW-1:0] victim_o
);
  logic [IW-1:0] age_q   [N];
  logic [IW-1:0] age_mid [N];
  logic [IW-1:0] age_d   [N];

  always_comb begin
    age_mid = age_q;
    if (a_en_i) begin
      for (int i = 0; i < N; i++)
        if (age_q[i] < age_q[a_idx_i]) age_mid[i] = age_q[i] + 1'b1;
      age_mid[a_idx_i] = '0;
    end
    age_d = age_mid;
    if (b_en_i) begin
      for (int i = 0; i < N; i++)
        if (age_mid[i] < age_mid[b_idx_i]) age_d[i] = age_mid[i] + 1'b1;
      age_d[b_idx_i] = '0;
    end
    // victim sees the first touch
    victim_o = '0;
    for (int i = 0; i < N; i++)
      if (age_mid[i] == IW'(N - 1)) victim_o = IW'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else begin
      age_q <= age_d;
    end
  end
endmodule

// File: rtl/memo_sat_cnt.sv
module memo_sat_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_o <= '0;
    else if (inc_i && !(&cnt_o))    cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/memo_set.sv
module memo_set #(
  parameter int unsigned OPC_W  = 6,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WAYS   = 4,
  localparam int unsigned WIW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              tag_vld_o,
  output logic [OPC_W-1:0]  tag_o,
  input  logic [DATA_W-1:0] lk_a_i,
  input  logic [DATA_W-1:0] lk_b_i,
  input  logic              lk_touch_i,
  output logic              lk_hit_o,
  output logic [DATA_W-1:0] lk_res_o,
  input  logic [DATA_W-1:0] up_a_i,
  input  logic [DATA_W-1:0] up_b_i,
  output logic              up_match_o,
  output logic              up_full_o,
  input  logic              up_wr_i,
  input  logic              up_retag_i,
  input  logic [OPC_W-1:0]  up_opc_i,
  input  logic [DATA_W-1:0] up_res_i
);
  logic              vld_q [WAYS];
  logic [DATA_W-1:0] a_q   [WAYS];
  logic [DATA_W-1:0] b_q   [WAYS];
  logic [DATA_W-1:0] r_q   [WAYS];

  logic [WIW-1:0] lk_way, match_way, free_way, lru_way, up_way;
  logic           has_free;

  always_comb begin
    lk_hit_o   = 1'b0;
    lk_res_o   = '0;
    lk_way     = '0;
    up_match_o = 1'b0;
    match_way  = '0;
    has_free   = 1'b0;
    free_way   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld_q[w] && a_q[w] == lk_a_i && b_q[w] == lk_b_i) begin
        lk_hit_o = 1'b1;
        lk_res_o = r_q[w];
        lk_way   = WIW'(w);
      end
      if (vld_q[w] && a_q[w] == up_a_i && b_q[w] == up_b_i) begin
        up_match_o = 1'b1;
        match_way  = WIW'(w);
      end
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_q[w]) begin
        has_free = 1'b1;
        free_way = WIW'(w);
      end
    end
    up_full_o = !has_free;
    if (up_retag_i)      up_way = '0;
    else if (up_match_o) up_way = match_way;
    else if (has_free)   up_way = free_way;
    else                 up_way = lru_way;
  end

  memo_lru_age #(.N(WAYS)) u_way_lru (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .a_en_i   (lk_touch_i && lk_hit_o),
    .a_idx_i  (lk_way),
    .b_en_i   (up_wr_i),
    .b_idx_i  (up_way),
    .victim_o (lru_way)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_vld_o <= 1'b0;
      tag_o     <= '0;
      for (int w = 0; w < WAYS; w++) vld_q[w] <= 1'b0;
    end else if (up_wr_i) begin
      if (up_retag_i) begin
        tag_vld_o <= 1'b1;
        tag_o     <= up_opc_i;
        for (int w = 0; w < WAYS; w++) vld_q[w] <= 1'b0;
      end
      vld_q[up_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (up_wr_i) begin
      a_q[up_way] <= up_a_i;
      b_q[up_way] <= up_b_i;
      r_q[up_way] <= up_res_i;
    end
  end
endmodule

// File: rtl/memo_table.sv
module memo_table
  import memo_pkg::*;
#(
  parameter int unsigned OPC_W  = MEMO_OPC_W,
  parameter int unsigned DATA_W = MEMO_DATA_W,
  parameter int unsigned SETS   = MEMO_SETS,
  parameter int unsigned WAYS   = MEMO_WAYS,
  parameter int unsigned CNT_W  = MEMO_CNT_W,
  localparam int unsigned SIW = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [OPC_W-1:0]  lk_opc_i,
  input  logic [DATA_W-1:0] lk_a_i,
  input  logic [DATA_W-1:0] lk_b_i,
  output logic              lk_hit_o,
  output logic [DATA_W-1:0] lk_result_o,
  input  logic              up_valid_i,
  input  logic [OPC_W-1:0]  up_opc_i,
  input  logic [DATA_W-1:0] up_a_i,
  input  logic [DATA_W-1:0] up_b_i,
  input  logic [DATA_W-1:0] up_result_i,
  output logic [CNT_W-1:0]  ent_evict_cnt_o,
  output logic [CNT_W-1:0]  set_evict_cnt_o
);
  logic              tag_vld  [SETS];
  logic [OPC_W-1:0]  tag      [SETS];
  logic              s_lk_hit [SETS];
  logic [DATA_W-1:0] s_lk_res [SETS];
  logic              s_match  [SETS];
  logic              s_full   [SETS];
  logic              lk_sel   [SETS];
  logic              up_wr    [SETS];
  logic              up_retag [SETS];

  logic [SIW-1:0] lk_set, own_idx, free_idx, tgt_set, lru_set;
  logic           own_found, free_found;
  upd_kind_e      kind;

  // lookup side
  always_comb begin
    lk_hit_o    = 1'b0;
    lk_result_o = '0;
    lk_set      = '0;
    for (int s = 0; s < SETS; s++) begin
      lk_sel[s] = lk_valid_i && tag_vld[s] && tag[s] == lk_opc_i && s_lk_hit[s];
      if (lk_sel[s]) begin
        lk_hit_o    = 1'b1;
        lk_result_o = s_lk_res[s];
        lk_set      = SIW'(s);
      end
    end
  end

  // update side: pick the target set and classify the write
  always_comb begin
    own_found  = 1'b0;
    own_idx    = '0;
    free_found = 1'b0;
    free_idx   = '0;
    for (int s = 0; s < SETS; s++) begin
      if (tag_vld[s] && tag[s] == up_opc_i) begin
        own_found = 1'b1;
        own_idx   = SIW'(s);
      end
    end
    for (int s = SETS - 1; s >= 0; s--) begin
      if (!tag_vld[s]) begin
        free_found = 1'b1;
        free_idx   = SIW'(s);
      end
    end
    if (own_found)       tgt_set = own_idx;
    else if (free_found) tgt_set = free_idx;
    else                 tgt_set = lru_set;

    if (!up_valid_i)            kind = UPD_IDLE;
    else if (own_found) begin
      if (s_match[own_idx])     kind = UPD_REFRESH;
      else if (s_full[own_idx]) kind = UPD_REPLACE;
      else                      kind = UPD_FILL;
    end
    else if (free_found)        kind = UPD_CLAIM;
    else                        kind = UPD_EVICT;

    for (int s = 0; s < SETS; s++) begin
      up_wr[s]    = up_valid_i && tgt_set == SIW'(s);
      up_retag[s] = up_wr[s] && (kind == UPD_CLAIM || kind == UPD_EVICT);
    end
  end

  for (genvar g = 0; g < SETS; g++) begin : g_set
    memo_set #(
      .OPC_W  (OPC_W),
      .DATA_W (DATA_W),
      .WAYS   (WAYS)
    ) u_set (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tag_vld_o  (tag_vld[g]),
      .tag_o      (tag[g]),
      .lk_a_i     (lk_a_i),
      .lk_b_i     (lk_b_i),
      .lk_touch_i (lk_sel[g]),
      .lk_hit_o   (s_lk_hit[g]),
      .lk_res_o   (s_lk_res[g]),
      .up_a_i     (up_a_i),
      .up_b_i     (up_b_i),
      .up_match_o (s_match[g]),
      .up_full_o  (s_full[g]),
      .up_wr_i    (up_wr[g]),
      .up_retag_i (up_retag[g]),
      .up_opc_i   (up_opc_i),
      .up_res_i   (up_result_i)
    );
  end

  memo_lru_age #(.N(SETS)) u_set_lru (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .a_en_i   (lk_hit_o),
    .a_idx_i  (lk_set),
    .b_en_i   (up_valid_i),
    .b_idx_i  (tgt_set),
    .victim_o (lru_set)
  );

  memo_sat_cnt #(.W(CNT_W)) u_ent_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (kind == UPD_REPLACE),
    .cnt_o  (ent_evict_cnt_o)
  );

  memo_sat_cnt #(.W(CNT_W)) u_set_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (kind == UPD_EVICT),
    .cnt_o  (set_evict_cnt_o)
  );
endmodule

// File: rtl/memo_table_chk.sv
module memo_table_chk #(
  parameter int unsigned OPC_W  = 6,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lk_valid_i,
  input logic [OPC_W-1:0]  lk_opc_i,
  input logic [DATA_W-1:0] lk_a_i,
  input logic [DATA_W-1:0] lk_b_i,
  input logic              lk_hit_o,
  input logic [DATA_W-1:0] lk_result_o,
  input logic              up_valid_i,
  input logic [OPC_W-1:0]  up_opc_i,
  input logic [DATA_W-1:0] up_a_i,
  input logic [DATA_W-1:0] up_b_i,
  input logic [DATA_W-1:0] up_result_i,
  input logic [CNT_W-1:0]  ent_evict_cnt_o,
  input logic [CNT_W-1:0]  set_evict_cnt_o
);
  AST_NO_HIT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |-> !lk_hit_o); // R1

  AST_UPDATE_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(up_valid_i) && lk_valid_i && lk_opc_i == $past(up_opc_i) &&
     lk_a_i == $past(up_a_i) && lk_b_i == $past(up_b_i))
    |-> (lk_hit_o && lk_result_o == $past(up_result_i))); // R2

  AST_ENT_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_evict_cnt_o != $past(ent_evict_cnt_o))
    |-> (ent_evict_cnt_o == $past(ent_evict_cnt_o) + 1'b1 && $past(up_valid_i))); // R8

  AST_ENT_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&ent_evict_cnt_o) |=> (&ent_evict_cnt_o)); // R8

  AST_SET_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_evict_cnt_o != $past(set_evict_cnt_o))
    |-> (set_evict_cnt_o == $past(set_evict_cnt_o) + 1'b1 && $past(up_valid_i))); // R9

  AST_SET_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&set_evict_cnt_o) |=> (&set_evict_cnt_o)); // R9
endmodule

bind memo_table memo_table_chk #(
  .OPC_W  (OPC_W),
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W)
) u_chk (.*);

// File: tb/memo_table_bench.sv
module memo_table_bench;
  localparam int NS = 4;
  localparam int NW = 4;
  localparam int OW = 6;
  localparam int DW = 16;
  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          lk_valid_i = 1'b0;
  logic [OW-1:0] lk_opc_i = '0;
  logic [DW-1:0] lk_a_i = '0, lk_b_i = '0;
  logic          lk_hit_o;
  logic [DW-1:0] lk_result_o;
  logic          up_valid_i = 1'b0;
  logic [OW-1:0] up_opc_i = '0;
  logic [DW-1:0] up_a_i = '0, up_b_i = '0, up_result_i = '0;
  logic [CW-1:0] ent_evict_cnt_o, set_evict_cnt_o;

  always #5 clk = ~clk;

  memo_table #(.OPC_W(OW), .DATA_W(DW), .SETS(NS), .WAYS(NW), .CNT_W(CW)) u_memo_table (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_valid_i(lk_valid_i), .lk_opc_i(lk_opc_i), .lk_a_i(lk_a_i), .lk_b_i(lk_b_i),
    .lk_hit_o(lk_hit_o), .lk_result_o(lk_result_o),
    .up_valid_i(up_valid_i), .up_opc_i(up_opc_i), .up_a_i(up_a_i), .up_b_i(up_b_i),
    .up_result_i(up_result_i),
    .ent_evict_cnt_o(ent_evict_cnt_o), .set_evict_cnt_o(set_evict_cnt_o)
  );

  // behavioural reference: recency by time stamps
  int n_cmp = 0, n_bad = 0;
  int tick = 0;
  bit m_tv [NS];
  int m_tag [NS];
  int m_sst [NS];
  bit m_ev [NS][NW];
  int m_ea [NS][NW], m_eb [NS][NW], m_er [NS][NW], m_wst [NS][NW];
  int m_ecnt = 0, m_scnt = 0;
  bit exp_hit;
  int exp_res, exp_set, exp_way;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    tick = 0; m_ecnt = 0; m_scnt = 0;
    for (int s = 0; s < NS; s++) begin
      m_tv[s] = 0; m_tag[s] = 0; m_sst[s] = -s;
      for (int w = 0; w < NW; w++) begin
        m_ev[s][w] = 0; m_wst[s][w] = -w;
      end
    end
  endtask

  task automatic model_lookup();
    exp_hit = 0; exp_res = 0; exp_set = 0; exp_way = 0;
    if (lk_valid_i)
      for (int s = 0; s < NS; s++)
        if (m_tv[s] && m_tag[s] == int'(lk_opc_i))
          for (int w = 0; w < NW; w++)
            if (m_ev[s][w] && m_ea[s][w] == int'(lk_a_i) && m_eb[s][w] == int'(lk_b_i)) begin
              exp_hit = 1; exp_res = m_er[s][w]; exp_set = s; exp_way = w;
            end
  endtask

  task automatic model_edge();
    int s, w;
    bit found;
    if (exp_hit) begin
      tick++; m_sst[exp_set] = tick; m_wst[exp_set][exp_way] = tick;
    end
    if (!up_valid_i) return;
    tick++;
    found = 0; s = 0;
    for (int i = 0; i < NS; i++)
      if (m_tv[i] && m_tag[i] == int'(up_opc_i)) begin found = 1; s = i; end
    if (found) begin
      w = -1;
      for (int i = 0; i < NW; i++)
        if (m_ev[s][i] && m_ea[s][i] == int'(up_a_i) && m_eb[s][i] == int'(up_b_i)) w = i;
      if (w < 0)
        for (int i = NW - 1; i >= 0; i--) if (!m_ev[s][i]) w = i;
      if (w < 0) begin
        w = 0;
        for (int i = 1; i < NW; i++) if (m_wst[s][i] < m_wst[s][w]) w = i;
        if (m_ecnt < CMAX) m_ecnt++;
      end
    end else begin
      s = -1;
      for (int i = NS - 1; i >= 0; i--) if (!m_tv[i]) s = i;
      if (s < 0) begin
        s = 0;
        for (int i = 1; i < NS; i++) if (m_sst[i] < m_sst[s]) s = i;
        if (m_scnt < CMAX) m_scnt++;
      end
      m_tv[s] = 1; m_tag[s] = int'(up_opc_i);
      for (int i = 0; i < NW; i++) m_ev[s][i] = 0;
      w = 0;
    end
    m_ev[s][w] = 1; m_ea[s][w] = int'(up_a_i); m_eb[s][w] = int'(up_b_i);
    m_er[s][w] = int'(up_result_i);
    m_sst[s] = tick; m_wst[s][w] = tick;
  endtask

  // one clock: drive, compare against the model, advance both
  task automatic cyc(bit lv, int lo, int la, int lb, bit uv, int uo, int ua, int ub, int ur);
    lk_valid_i = lv; lk_opc_i = OW'(lo); lk_a_i = DW'(la); lk_b_i = DW'(lb);
    up_valid_i = uv; up_opc_i = OW'(uo); up_a_i = DW'(ua); up_b_i = DW'(ub); up_result_i = DW'(ur);
    #1;
    model_lookup();
    chk("R1 hit", int'(lk_hit_o), int'(exp_hit));
    if (exp_hit) chk("R1 result", int'(lk_result_o), exp_res);
    chk("R8 entry evictions", int'(ent_evict_cnt_o), m_ecnt);
    chk("R9 set evictions", int'(set_evict_cnt_o), m_scnt);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic upd(int o, int a, int b, int r);
    cyc(0, 0, 0, 0, 1, o, a, b, r);
  endtask

  // lookup with a fixed expectation written from the requirements
  task automatic look(string tag, int o, int a, int b, bit eh, int er);
    lk_valid_i = 1; lk_opc_i = OW'(o); lk_a_i = DW'(a); lk_b_i = DW'(b);
    up_valid_i = 0;
    #1;
    chk(tag, int'(lk_hit_o), int'(eh));
    if (eh) chk(tag, int'(lk_result_o), er);
    cyc(1, o, a, b, 0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R10: empty after reset
    chk("R10 entry count", int'(ent_evict_cnt_o), 0);
    chk("R10 set count", int'(set_evict_cnt_o), 0);
    look("R10 empty", 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R2/R4: fill one set
    upd(1, 1, 1, 11);
    look("R2 visible next cycle", 1, 1, 1, 1, 11);
    upd(1, 2, 2, 22);
    upd(1, 3, 3, 33);
    upd(1, 4, 4, 44);
    look("R6 touch way", 1, 1, 1, 1, 11);
    upd(1, 5, 5, 55);
    chk("R8 one replacement", int'(ent_evict_cnt_o), 1);
    look("R4 LRU way replaced", 1, 2, 2, 0, 0);
    look("R6 touched way kept", 1, 1, 1, 1, 11);
    look("R1 operand swap misses", 1, 4, 3, 0, 0);

    // R7: refresh in place
    upd(1, 3, 3, 99);
    look("R7 refreshed result", 1, 3, 3, 1, 99);
    chk("R7 no eviction", int'(ent_evict_cnt_o), 1);
    look("R7 neighbour kept", 1, 4, 4, 1, 44);

    // R5: claim remaining sets then evict the oldest
    upd(2, 7, 7, 72);
    upd(3, 7, 7, 73);
    upd(4, 7, 7, 74);
    look("R1 opcode distinguishes", 2, 1, 1, 0, 0);
    look("R6 touch set", 1, 1, 1, 1, 11);
    upd(5, 8, 8, 88);
    chk("R9 one set eviction", int'(set_evict_cnt_o), 1);
    look("R5 evicted opcode misses", 2, 7, 7, 0, 0);
    look("R5 new opcode hits", 5, 8, 8, 1, 88);
    look("R5 touched set survives", 1, 1, 1, 1, 11);

    // R3: second entry for owned opcode stays in its set
    upd(5, 9, 9, 90);
    chk("R3 no set eviction", int'(set_evict_cnt_o), 1);
    look("R3 both entries", 5, 8, 8, 1, 88);
    look("R3 both entries", 5, 9, 9, 1, 90);

    // R6: same-cycle lookup on the oldest set and evicting update
    look("R6 order", 4, 7, 7, 1, 74);
    look("R6 order", 5, 9, 9, 1, 90);
    look("R6 order", 1, 1, 1, 1, 11);
    lk_valid_i = 1; lk_opc_i = 3; lk_a_i = 7; lk_b_i = 7; #1;
    chk("R6 concurrent lookup", int'(lk_hit_o), 1);
    cyc(1, 3, 7, 7, 1, 6, 1, 2, 12);
    look("R6 looked-up set kept", 3, 7, 7, 1, 73);
    look("R6 next oldest evicted", 4, 7, 7, 0, 0);
    look("R5 fresh set way 0", 6, 1, 2, 1, 12);

    // mixed traffic against the model
    for (int i = 0; i < 3000; i++)
      cyc($urandom_range(1, 0), $urandom_range(7, 0), $urandom_range(2, 0), $urandom_range(2, 0),
          $urandom_range(1, 0), $urandom_range(7, 0), $urandom_range(2, 0), $urandom_range(2, 0),
          $urandom_range(255, 0));

    // R8/R9: saturation
    for (int i = 0; i < 20; i++) upd(40, i, 100, i);
    for (int i = 0; i < 20; i++) upd(41 + i, 0, 0, i);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 saturated", int'(ent_evict_cnt_o), CMAX);
    chk("R9 saturated", int'(set_evict_cnt_o), CMAX);
    summary();
  end
endmodule